// File: doc/BRIEF.md
# Interrupt Enable and Priority Controller

This block sits between six interrupt-raising peripherals and a processor core. Each peripheral delivers a one-cycle request pulse, which the block captures in a per-source pending latch. A pending source is offered to the core only when its own enable bit is 1 and a global master enable is 1. Among the offered sources, the one with the lowest index wins. The block then drives a request line and a 3-bit source number that the core uses to select a vector.

The core works the block through four one-cycle strobes: enable-interrupts, disable-interrupts, acknowledge and return-from-interrupt. It also reads and writes the enable bits through a 4-bit register port. The master enable drops by itself when an interrupt is accepted and comes back on return, so nested entry cannot happen unless software asks for it. Once a source number has been presented with the request, it stays fixed until that request is acknowledged or withdrawn.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pulse on `src_pulse[k]` sets pending latch k at the next clock edge. The latch stays set while source k is disabled or the master enable is 0. A set latch becomes visible on `irq_req` as soon as the gating allows it.
- R2: `irq_req` is 1 exactly when the master enable is 1 and the presented source is both pending and enabled.
- R3: `irq_src` encodes the sources as 0 to 5, in the order: external pin A, external pin B, serial group C, serial group A, byte timer, serial group B. When no source is held, the lowest-numbered pending and enabled source is presented.
- R4: While `irq_req` is 1 and no acknowledge is given, `irq_src` does not change in the next cycle, even if a higher-priority source becomes pending.
- R5: The master enable is cleared by `di_stb` or by an accepted acknowledge, and set by `ei_stb` or `reti_stb`. A clear and a set in the same cycle leave it at 0.
- R6: An acknowledge while `irq_req` is 1 clears the pending latch of the source shown on `irq_src`. An acknowledge while `irq_req` is 0 has no effect.
- R7: If source k is acknowledged in the same cycle that `src_pulse[k]` is 1, latch k stays set.
- R8: The register port read is combinational from `reg_addr`. Address 0 returns the master enable in bit 0, with bits 3..1 reading 0. Address 1 holds the enables of sources 0 to 3 in bits 0 to 3. Address 2 holds the enables of sources 4 and 5 in bits 0 and 1, and its bits 2 and 3 read 0. Address 3 reads 0. A write to address 1 or 2 takes effect at the next edge. A write to address 0 or 3, and writes to bits 2 and 3 at address 2, change nothing.
- R9: Synchronous active-low reset clears all enables, the master enable, every pending latch and the held source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | 6 | One-cycle request pulses, bit k = source k |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| ack_stb | input | 1 | Interrupt acknowledge strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| reg_addr | input | 2 | Register port address |
| reg_we | input | 1 | Register port write enable |
| reg_wdata | input | 4 | Register port write data |
| reg_rdata | output | 4 | Register port read data |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | 3 | Number of the presented source |

## Verification
Every state element updates at one clock edge, and `irq_req` and `irq_src` are combinational from that state. The effect of a pulse, strobe or register write is therefore due in the cycle that follows the edge that captured it. `reg_rdata` follows `reg_addr` within the same cycle. The bench drives inputs one time unit after the rising edge and advances its behavioural model on the rising edge. It compares request, source and read data at the falling edge, and its directed checks sample one unit after the edge that follows each stimulus.

// File: rtl/irq_pkg.sv
// Package: shared sizing constants for the interrupt controller.
// Assumes: one package per build; values are defaults only, modules take parameters.
package irq_pkg;
    localparam int IRQ_NUM_SRC = 6;
    localparam int IRQ_IDX_W   = 3;
    localparam int IRQ_REG_W   = 4;
    localparam int IRQ_ADDR_W  = 2;
endpackage

// File: rtl/irq_pending_bank.sv
// Module: one pending latch per source.
// Function: a latch sets on its pulse and clears on its clear bit; set wins.
// Assumes: clr is at most one-hot and comes only from an accepted acknowledge.
module irq_pending_bank #(
    parameter int NUM_SRC = irq_pkg::IRQ_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pulse,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        // Latch request k; a fresh pulse overrides a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[k] <= 1'b0;
            else        pend[k] <= pulse[k] | (pend[k] & ~clr[k]);
        end

        p_pend_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[k] |=> pend[k]);
        p_pend_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[k] && !clr[k]) |=> pend[k]);
        p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !pulse[k]) |=> !pend[k]);
        p_ack_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && pulse[k]) |=> pend[k]);
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority pick, lowest index wins.
// Assumes: IDX_W is wide enough to number NUM_SRC sources.
module irq_prio_pick #(
    parameter int NUM_SRC = irq_pkg::IRQ_NUM_SRC,
    parameter int IDX_W   = irq_pkg::IRQ_IDX_W
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the lowest priority up so the lowest index is written last.
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end

    // Any source eligible at all.
    assign any = |elig;
endmodule

// File: rtl/irq_regfile.sv
// Module: enable bits, master enable and the nibble-wide register port.
// Function: address 0 shows the master enable; enables fill addresses from 1,
//           REG_W bits each, with unused bits reading 0.
// Assumes: the master enable changes only through strobes, never by a write.
module irq_regfile #(
    parameter int NUM_SRC = irq_pkg::IRQ_NUM_SRC,
    parameter int REG_W   = irq_pkg::IRQ_REG_W,
    parameter int ADDR_W  = irq_pkg::IRQ_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ei_stb,
    input  logic               di_stb,
    input  logic               reti_stb,
    input  logic               ack_ok,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [NUM_SRC-1:0] en,
    output logic               master
);
    localparam int NUM_EN_REGS = (NUM_SRC + REG_W - 1) / REG_W;
    localparam int PAD_W       = NUM_EN_REGS * REG_W;

    logic [PAD_W-1:0] en_pad;
    logic [REG_W-1:0] en_reg [NUM_EN_REGS];

    // Master enable: clears win over sets.
    always_ff @(posedge clk) begin
        if (!rst_n)                  master <= 1'b0;
        else if (di_stb || ack_ok)   master <= 1'b0;
        else if (ei_stb || reti_stb) master <= 1'b1;
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
        localparam int RA = 1 + k / REG_W;
        localparam int RB = k % REG_W;
        // Enable bit k takes bit RB of a write to its register.
        always_ff @(posedge clk) begin
            if (!rst_n) en[k] <= 1'b0;
            else if (reg_we && (reg_addr == ADDR_W'(RA))) en[k] <= reg_wdata[RB];
        end
    end

    assign en_pad = PAD_W'(en);
    for (genvar r = 0; r < NUM_EN_REGS; r++) begin : g_view
        assign en_reg[r] = en_pad[r*REG_W +: REG_W];
    end

    // Read mux: master at 0, enable registers above, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) reg_rdata[0] = master;
        for (int r = 0; r < NUM_EN_REGS; r++) begin
            if (reg_addr == ADDR_W'(r + 1)) reg_rdata = en_reg[r];
        end
    end

    p_master_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (di_stb || ack_ok) |=> !master);
    p_master_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ei_stb || reti_stb) && !di_stb && !ack_ok) |=> master);
    p_master_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ei_stb && !reti_stb && !di_stb && !ack_ok) |=> $stable(master));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: interrupt enable and priority controller (top).
// Function: gates pending requests by per-source and master enables, presents
//           the highest-priority one and holds its number until acknowledged.
// Assumes: strobes are one cycle wide; an acknowledge refers to irq_src.
module irq_prio_ctrl #(
    parameter int NUM_SRC = irq_pkg::IRQ_NUM_SRC,
    parameter int IDX_W   = irq_pkg::IRQ_IDX_W,
    parameter int REG_W   = irq_pkg::IRQ_REG_W,
    parameter int ADDR_W  = irq_pkg::IRQ_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               ei_stb,
    input  logic               di_stb,
    input  logic               ack_stb,
    input  logic               reti_stb,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_src
);
    localparam int SLOTS = 1 << IDX_W;

    logic [NUM_SRC-1:0] pend, en, elig, clr;
    logic [SLOTS-1:0]   elig_ext;
    logic               master, any, ack_ok, hold_v;
    logic [IDX_W-1:0]   pick_idx, hold_idx;

    irq_pending_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .pulse(src_pulse), .clr(clr), .pend(pend)
    );

    irq_regfile #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb),
        .reti_stb(reti_stb), .ack_ok(ack_ok), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en(en), .master(master)
    );

    assign elig     = pend & en;
    assign elig_ext = SLOTS'(elig);

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .elig(elig), .any(any), .idx(pick_idx)
    );

    // Present the held source if one is held, else the fresh pick.
    always_comb begin
        if (hold_v) begin
            irq_src = hold_idx;
            irq_req = master & elig_ext[hold_idx];
        end else begin
            irq_src = pick_idx;
            irq_req = master & any;
        end
    end

    // An acknowledge counts only while a request is shown.
    assign ack_ok = ack_stb & irq_req;
    assign clr    = ack_ok ? (NUM_SRC'(1) << irq_src) : '0;

    // Hold the presented number while the request stays unacknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_idx <= '0;
        end else begin
            hold_v   <= irq_req & ~ack_ok;
            hold_idx <= irq_src;
        end
    end

    p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (master && (elig != '0)));
    p_src_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack_stb) |=> (!irq_req || $stable(irq_src)));
    p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> !irq_req);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_pulse = '0;
    logic       ei_stb = 0, di_stb = 0, ack_stb = 0, reti_stb = 0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       irq_req;
    logic [2:0] irq_src;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    // Behavioural reference state.
    bit m_pend[6], m_en[6];
    bit m_master, m_hold_v;
    int m_hold_i;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ei_stb(ei_stb),
        .di_stb(di_stb), .ack_stb(ack_stb), .reti_stb(reti_stb),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_src(irq_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_src();
        if (m_hold_v) return m_hold_i;
        for (int k = 0; k < 6; k++) if (m_pend[k] && m_en[k]) return k;
        return 0;
    endfunction

    function automatic bit m_req();
        if (m_hold_v) return m_master && m_pend[m_hold_i] && m_en[m_hold_i];
        for (int k = 0; k < 6; k++) if (m_pend[k] && m_en[k]) return m_master;
        return 0;
    endfunction

    function automatic int m_rdata(int a);
        int v = 0;
        if (a == 0) v = m_master;
        else if (a == 1) v = m_en[0] | (m_en[1] << 1) | (m_en[2] << 2) | (m_en[3] << 3);
        else if (a == 2) v = m_en[4] | (m_en[5] << 1);
        return v;
    endfunction

    // Advance the reference on every rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin m_pend[k] = 0; m_en[k] = 0; end
            m_master = 0; m_hold_v = 0; m_hold_i = 0;
        end else begin
            bit r, acc;
            int s;
            r = m_req(); s = m_src();
            acc = ack_stb && r;
            for (int k = 0; k < 6; k++)
                m_pend[k] = src_pulse[k] || (m_pend[k] && !(acc && s == k));
            if (acc || di_stb) m_master = 0;
            else if (ei_stb || reti_stb) m_master = 1;
            if (reg_we && reg_addr == 1) for (int k = 0; k < 4; k++) m_en[k] = reg_wdata[k];
            if (reg_we && reg_addr == 2) begin m_en[4] = reg_wdata[0]; m_en[5] = reg_wdata[1]; end
            m_hold_v = r && !acc;
            m_hold_i = s;
        end
        if (cycles > WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Compare against the reference in mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 irq_req vs model", irq_req, m_req());
            if (m_req()) chk("R3 irq_src vs model", irq_src, m_src());
            chk("R8 reg_rdata vs model", reg_rdata, m_rdata(reg_addr));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        src_pulse = '0; ei_stb = 0; di_stb = 0; ack_stb = 0; reti_stb = 0; reg_we = 0;
    endtask

    task automatic wr(int a, int d);
        reg_addr = 2'(a); reg_wdata = 4'(d); reg_we = 1; tick();
    endtask

    task automatic rd(int a, int exp, string tag);
        reg_addr = 2'(a); #1; chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R9 reset state
        chk("R9 irq_req after reset", irq_req, 0);
        rd(0, 0, "R9 master after reset"); rd(1, 0, "R9 enables lo after reset");
        rd(2, 0, "R9 enables hi after reset");
        tick();
        // R8 register port
        wr(1, 15); rd(1, 15, "R8 addr1 write");
        wr(2, 15); rd(2, 3, "R8 addr2 upper bits zero");
        tick();
        wr(0, 1); rd(0, 0, "R8 addr0 write ignored");
        wr(3, 15); rd(3, 0, "R8 addr3 reads zero"); rd(1, 15, "R8 addr3 write no effect");
        tick();
        wr(1, 0); wr(2, 0);
        ei_stb = 1; tick(); rd(0, 1, "R5 ei sets master");
        // R1 pending held while disabled
        src_pulse[2] = 1; tick(); chk("R1 disabled source no request", irq_req, 0);
        tick(); tick(); chk("R1 still no request", irq_req, 0);
        wr(1, 4'b0100); chk("R1 latched request appears", irq_req, 1);
        chk("R1 source number", irq_src, 2);
        wr(1, 15);
        src_pulse[0] = 1; tick();
        chk("R4 source held", irq_src, 2); chk("R4 request held", irq_req, 1);
        ack_stb = 1; tick(); chk("R6 ack drops request", irq_req, 0);
        rd(0, 0, "R5 ack clears master");
        reti_stb = 1; tick(); chk("R5 reti restores request", irq_req, 1);
        chk("R3 next source", irq_src, 0); rd(0, 1, "R5 reti sets master");
        // R7 ack and pulse same cycle
        ack_stb = 1; src_pulse[0] = 1; tick(); chk("R7 request off after ack", irq_req, 0);
        ei_stb = 1; tick(); chk("R7 latch kept", irq_req, 1); chk("R7 source", irq_src, 0);
        // R6 ignored ack
        di_stb = 1; tick(); chk("R5 di drops request", irq_req, 0);
        ack_stb = 1; tick();
        ei_stb = 1; tick(); chk("R6 ignored ack keeps latch", irq_req, 1);
        ack_stb = 1; tick();
        ei_stb = 1; tick(); chk("R6 accepted ack clears latch", irq_req, 0);
        // R3 priority among new sources
        wr(2, 3);
        src_pulse = 6'b101000; tick(); chk("R3 lower index wins", irq_src, 3);
        ack_stb = 1; tick(); reti_stb = 1; tick();
        chk("R3 remaining source", irq_src, 5); chk("R3 request", irq_req, 1);
        ack_stb = 1; tick(); ei_stb = 1; tick(); chk("R6 all cleared", irq_req, 0);
        // R5 clear wins
        di_stb = 1; ei_stb = 1; tick(); rd(0, 0, "R5 clear wins over set");
        tick();
        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            src_pulse = ($urandom % 4 == 0) ? 6'($urandom) : '0;
            ei_stb   = ($urandom % 8 == 0);
            di_stb   = ($urandom % 16 == 0);
            ack_stb  = ($urandom % 3 == 0);
            reti_stb = ($urandom % 6 == 0);
            reg_addr = 2'($urandom);
            reg_we   = ($urandom % 10 == 0);
            reg_wdata = 4'($urandom);
            tick();
        end
        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule